// File: doc/BRIEF.md
# Exception Vector Address Generator

This block produces the instruction fetch address a processor core jumps to when it takes an exception or an interrupt. It holds two software-writable registers, a 4 KB-aligned exception base and a 5-bit interrupt vector spacing field. From these, a boot-mode select input, a single- or multi-vector mode input, the event kind and the interrupt vector number, it forms a 32-bit entry address. The address is latched on an exception-taken strobe.

With the boot select high, every event lands in a fixed, start-up-safe boot region. With it low, events land at the programmed base plus an offset chosen by the event kind. General exceptions use base + 0x180. Interrupts use base + 0x200, plus, in multi-vector mode, the vector number times the spacing in bytes. A spacing field value of N means N × 32 bytes between consecutive interrupt entries.

Top module: `exc_vector_gen`

## Requirements
- R1: After reset, the base register reads 0x9FC01000, the spacing register reads 1, `entryValid` is 0 and `entryAddr` is 0.
- R2: A write with `regSel` = 0 loads the base register. Bits 11:0 always read back as zero and bits 31:12 hold the written value.
- R3: A write with `regSel` = 1 loads the spacing register from `regWrData[4:0]`. A read returns it zero-extended, with bits 31:5 zero.
- R4: With `bootVecSel` = 1, a general exception (`isIrq` = 0) yields 0xBFC00180.
- R5: With `bootVecSel` = 1, an interrupt yields 0xBFC00200, whatever the vector number, the mode bit and the spacing.
- R6: With `bootVecSel` = 0, a general exception yields base + 0x180.
- R7: With `bootVecSel` = 0 and `multiVec` = 0, every interrupt yields base + 0x200.
- R8: With `bootVecSel` = 0 and `multiVec` = 1, an interrupt yields base + 0x200 + `vecNum` × (spacing × 32), modulo 2^32. A spacing of 0 or a vector number of 0 gives base + 0x200.
- R9: `entryValid` is high for exactly the one cycle after a cycle with `takeStrobe` high. `entryAddr` changes only in that cycle and holds otherwise.
- R10: When a register write and `takeStrobe` fall in the same cycle, the latched address uses the register values from before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bootVecSel | input | 1 | 1 selects the fixed boot region |
| multiVec | input | 1 | 1 selects per-vector interrupt entries |
| isIrq | input | 1 | 1 for an interrupt, 0 for a general exception |
| vecNum | input | 6 | Interrupt vector number |
| takeStrobe | input | 1 | Exception taken this cycle |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 1 | 0 = base register, 1 = spacing register |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register picked by `regSel` |
| entryAddr | output | 32 | Latched entry address |
| entryValid | output | 1 | Pulses the cycle after a take |

## Verification
The bench builds the block with its default parameters: a 6-bit vector number, a 5-bit spacing field and 12 alignment bits. With these, the largest interrupt offset is 0x200 + 63 × 992 bytes. That brings within reach carries well past the 4 KB base alignment, as well as address wrap-around when random bases sit near the top of the space. The zero-spacing and zero-vector corners and the boot-mode override are driven directly. Random bases, spacings and vector numbers then exercise the shift-add product across its full operand range.

// File: rtl/exc_vector_gen_pkg.sv
package exc_vector_gen_pkg;

  typedef enum logic [2:0] {
    KIND_BOOT_GEN   = 3'd0,
    KIND_BOOT_IRQ   = 3'd1,
    KIND_GEN        = 3'd2,
    KIND_IRQ_SINGLE = 3'd3,
    KIND_IRQ_MULTI  = 3'd4
  } evg_kind_e;

  typedef struct packed {
    logic      wrBase;
    logic      wrSpacing;
    logic      rdSpacing;
    logic      capture;
    evg_kind_e kind;
  } evg_strobe_t;

endpackage

// File: rtl/exc_vector_gen_ctrl.sv
module exc_vector_gen_ctrl
  import exc_vector_gen_pkg::*;
(
  input  logic        bootVecSel,
  input  logic        multiVec,
  input  logic        isIrq,
  input  logic        takeStrobe,
  input  logic        regWrEn,
  input  logic        regSel,
  output evg_strobe_t strb
);

  always_comb begin
    strb.wrBase    = regWrEn && !regSel;
    strb.wrSpacing = regWrEn && regSel;
    strb.rdSpacing = regSel;
    strb.capture   = takeStrobe;
    if (bootVecSel)      strb.kind = isIrq ? KIND_BOOT_IRQ : KIND_BOOT_GEN;
    else if (!isIrq)     strb.kind = KIND_GEN;
    else if (multiVec)   strb.kind = KIND_IRQ_MULTI;
    else                 strb.kind = KIND_IRQ_SINGLE;
  end

endmodule

// File: rtl/exc_vector_gen_dp.sv
module exc_vector_gen_dp
  import exc_vector_gen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_NUM_W  = 6,
  parameter int SPACING_W  = 5,
  parameter int ALIGN_BITS = 12,
  parameter logic [ADDR_W-1:0] BOOT_BASE     = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BASE_RESET    = 32'h9FC0_1000,
  parameter logic [SPACING_W-1:0] SPACING_RESET = 5'd1,
  parameter logic [ADDR_W-1:0] GEN_OFFSET    = 32'h0000_0180,
  parameter logic [ADDR_W-1:0] IRQ_OFFSET    = 32'h0000_0200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  evg_strobe_t          strb,
  input  logic [VEC_NUM_W-1:0] vecNum,
  input  logic [ADDR_W-1:0]    regWrData,
  output logic [ADDR_W-1:0]    regRdData,
  output logic [ADDR_W-1:0]    entryAddr,
  output logic                 entryValid
);

  localparam int SP_BYTES_W = SPACING_W + 5;
  localparam int PROD_W     = SP_BYTES_W + VEC_NUM_W;
  localparam logic [ADDR_W-1:0] BASE_MASK = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [ADDR_W-1:0]    baseReg;
  logic [SPACING_W-1:0] spacingReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseReg    <= BASE_RESET & BASE_MASK;
      spacingReg <= SPACING_RESET;
    end else begin
      if (strb.wrBase)    baseReg    <= regWrData & BASE_MASK;
      if (strb.wrSpacing) spacingReg <= regWrData[SPACING_W-1:0];
    end
  end

  assign regRdData = strb.rdSpacing ? ADDR_W'(spacingReg) : baseReg;

  // Spacing in bytes: field value times 32.
  logic [SP_BYTES_W-1:0] spBytes;
  assign spBytes = {spacingReg, 5'b0};

  // Shift-add product vecNum * spBytes, one stage per vector-number bit.
  logic [PROD_W-1:0] partial [VEC_NUM_W+1];
  assign partial[0] = '0;
  for (genvar i = 0; i < VEC_NUM_W; i++) begin : g_mul
    assign partial[i+1] = partial[i] +
                          (vecNum[i] ? (PROD_W'(spBytes) << i) : PROD_W'(0));
  end

  logic [ADDR_W-1:0] selBase;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    unique case (strb.kind)
      KIND_BOOT_GEN:   begin selBase = BOOT_BASE; offset = GEN_OFFSET; end
      KIND_BOOT_IRQ:   begin selBase = BOOT_BASE; offset = IRQ_OFFSET; end
      KIND_GEN:        begin selBase = baseReg;   offset = GEN_OFFSET; end
      KIND_IRQ_MULTI:  begin selBase = baseReg;
                             offset  = IRQ_OFFSET + ADDR_W'(partial[VEC_NUM_W]); end
      default:         begin selBase = baseReg;   offset = IRQ_OFFSET; end
    endcase
    nextAddr = selBase + offset;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entryAddr  <= '0;
      entryValid <= 1'b0;
    end else begin
      entryValid <= strb.capture;
      if (strb.capture) entryAddr <= nextAddr;
    end
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_vector_gen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_NUM_W  = 6,
  parameter int SPACING_W  = 5,
  parameter int ALIGN_BITS = 12,
  parameter logic [ADDR_W-1:0] BOOT_BASE     = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] BASE_RESET    = 32'h9FC0_1000,
  parameter logic [SPACING_W-1:0] SPACING_RESET = 5'd1,
  parameter logic [ADDR_W-1:0] GEN_OFFSET    = 32'h0000_0180,
  parameter logic [ADDR_W-1:0] IRQ_OFFSET    = 32'h0000_0200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bootVecSel,
  input  logic                 multiVec,
  input  logic                 isIrq,
  input  logic [VEC_NUM_W-1:0] vecNum,
  input  logic                 takeStrobe,
  input  logic                 regWrEn,
  input  logic                 regSel,
  input  logic [ADDR_W-1:0]    regWrData,
  output logic [ADDR_W-1:0]    regRdData,
  output logic [ADDR_W-1:0]    entryAddr,
  output logic                 entryValid
);

  evg_strobe_t strb;

  exc_vector_gen_ctrl u_ctrl (
    .bootVecSel (bootVecSel),
    .multiVec   (multiVec),
    .isIrq      (isIrq),
    .takeStrobe (takeStrobe),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .strb       (strb)
  );

  exc_vector_gen_dp #(
    .ADDR_W        (ADDR_W),
    .VEC_NUM_W     (VEC_NUM_W),
    .SPACING_W     (SPACING_W),
    .ALIGN_BITS    (ALIGN_BITS),
    .BOOT_BASE     (BOOT_BASE),
    .BASE_RESET    (BASE_RESET),
    .SPACING_RESET (SPACING_RESET),
    .GEN_OFFSET    (GEN_OFFSET),
    .IRQ_OFFSET    (IRQ_OFFSET)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .vecNum     (vecNum),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .entryAddr  (entryAddr),
    .entryValid (entryValid)
  );

endmodule

// File: rtl/exc_vector_gen_checker.sv
module exc_vector_gen_checker #(
  parameter int ADDR_W     = 32,
  parameter int VEC_NUM_W  = 6,
  parameter int SPACING_W  = 5,
  parameter int ALIGN_BITS = 12,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0] GEN_OFFSET = 32'h0000_0180,
  parameter logic [ADDR_W-1:0] IRQ_OFFSET = 32'h0000_0200
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bootVecSel,
  input logic                 multiVec,
  input logic                 isIrq,
  input logic [VEC_NUM_W-1:0] vecNum,
  input logic                 takeStrobe,
  input logic                 regWrEn,
  input logic                 regSel,
  input logic [ADDR_W-1:0]    regWrData,
  input logic [ADDR_W-1:0]    regRdData,
  input logic [ADDR_W-1:0]    entryAddr,
  input logic                 entryValid
);

  localparam logic [ADDR_W-1:0] MASK = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  a_r9_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    takeStrobe |=> entryValid);

  a_r9_no_valid_without_take: assert property (@(posedge clk) disable iff (!rst_n)
    !takeStrobe |=> !entryValid);

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !takeStrobe |=> $stable(entryAddr));

  a_r4_boot_general: assert property (@(posedge clk) disable iff (!rst_n)
    (takeStrobe && bootVecSel && !isIrq) |=> entryAddr == BOOT_BASE + GEN_OFFSET);

  a_r5_boot_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (takeStrobe && bootVecSel && isIrq) |=> entryAddr == BOOT_BASE + IRQ_OFFSET);

  a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !regSel |-> regRdData[ALIGN_BITS-1:0] == '0);

  a_r3_spacing_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regSel |-> regRdData[ADDR_W-1:SPACING_W] == '0);

  a_r2_base_write: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regSel) |=> regSel || (regRdData == ($past(regWrData) & MASK)));

  a_r7_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (takeStrobe && !bootVecSel && isIrq && !multiVec && !regSel && !regWrEn)
      |=> entryAddr == $past(regRdData) + IRQ_OFFSET);

  a_r8_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (takeStrobe && !bootVecSel && isIrq && vecNum == '0 && !regSel && !regWrEn)
      |=> entryAddr == $past(regRdData) + IRQ_OFFSET);

  a_r6_general: assert property (@(posedge clk) disable iff (!rst_n)
    (takeStrobe && !bootVecSel && !isIrq && !regSel && !regWrEn)
      |=> entryAddr == $past(regRdData) + GEN_OFFSET);

endmodule

bind exc_vector_gen exc_vector_gen_checker #(
  .ADDR_W     (ADDR_W),
  .VEC_NUM_W  (VEC_NUM_W),
  .SPACING_W  (SPACING_W),
  .ALIGN_BITS (ALIGN_BITS),
  .BOOT_BASE  (BOOT_BASE),
  .GEN_OFFSET (GEN_OFFSET),
  .IRQ_OFFSET (IRQ_OFFSET)
) u_chk (.*);

// File: tb/exc_vector_gen_bench.sv
`timescale 1ns/1ps
module exc_vector_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bootVecSel = 1'b0;
  logic        multiVec = 1'b0;
  logic        isIrq = 1'b0;
  logic [5:0]  vecNum = '0;
  logic        takeStrobe = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] entryAddr;
  logic        entryValid;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mBase = 32'h9FC0_1000;
  logic [4:0]  mSpacing = 5'd1;

  always #4 clk = ~clk;

  exc_vector_gen u_exc_vector_gen (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic bev, input logic irq, input logic mv,
                                          input logic [5:0] vn, input logic [31:0] b,
                                          input logic [4:0] sp);
    if (bev) return irq ? 32'hBFC0_0200 : 32'hBFC0_0180;
    if (!irq) return b + 32'h180;
    if (!mv) return b + 32'h200;
    return b + 32'h200 + 32'(vn) * (32'(sp) * 32);
  endfunction

  task automatic writeReg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (sel) mSpacing = d[4:0]; else mBase = d & 32'hFFFF_F000;
  endtask

  task automatic readCheck(input logic sel, input string tag);
    @(negedge clk);
    regSel = sel;
    #1;
    check(tag, regRdData, sel ? 32'(mSpacing) : mBase);
  endtask

  task automatic take(input logic bev, input logic irq, input logic mv,
                      input logic [5:0] vn, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bootVecSel = bev; isIrq = irq; multiVec = mv; vecNum = vn; takeStrobe = 1'b1;
    e = expAddr(bev, irq, mv, vn, mBase, mSpacing);
    @(posedge clk); #1;
    check({tag, " valid"}, 32'(entryValid), 32'd1);
    check(tag, entryAddr, e);
    @(negedge clk);
    takeStrobe = 1'b0;
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1;
    check("R1 entryValid", 32'(entryValid), 32'd0);
    check("R1 entryAddr", entryAddr, 32'd0);
    readCheck(1'b0, "R1 base reset");
    readCheck(1'b1, "R1 spacing reset");
    // default setup multi vector: base 0x9FC01000, spacing 32 bytes
    take(1'b0, 1'b1, 1'b1, 6'd3, "R8 default multi");
    // R9 hold and single pulse
    held = entryAddr;
    @(posedge clk); #1;
    check("R9 valid drops", 32'(entryValid), 32'd0);
    check("R9 addr holds", entryAddr, held);
    // R4 / R5 boot region
    take(1'b1, 1'b0, 1'b1, 6'd9, "R4 boot general");
    take(1'b1, 1'b1, 1'b1, 6'd63, "R5 boot irq multi");
    take(1'b1, 1'b1, 1'b0, 6'd5, "R5 boot irq single");
    // R2 base write masks low bits
    writeReg(1'b0, 32'h8000_3ABC);
    readCheck(1'b0, "R2 base readback");
    // R3 spacing write masks upper bits
    writeReg(1'b1, 32'hFFFF_FFE7);
    readCheck(1'b1, "R3 spacing readback");
    take(1'b0, 1'b0, 1'b1, 6'd7, "R6 general");
    take(1'b0, 1'b1, 1'b0, 6'd40, "R7 single vector");
    take(1'b0, 1'b1, 1'b1, 6'd63, "R8 max vector");
    take(1'b0, 1'b1, 1'b1, 6'd0, "R8 vector zero");
    writeReg(1'b1, 32'd0);
    take(1'b0, 1'b1, 1'b1, 6'd44, "R8 spacing zero");
    writeReg(1'b1, 32'd31);
    writeReg(1'b0, 32'hFFFF_F000);
    take(1'b0, 1'b1, 1'b1, 6'd63, "R8 wrap");
    // R10 write and take in the same cycle
    @(negedge clk);
    bootVecSel = 1'b0; isIrq = 1'b0; multiVec = 1'b0; vecNum = '0;
    takeStrobe = 1'b1; regWrEn = 1'b1; regSel = 1'b0; regWrData = 32'h1234_5000;
    @(posedge clk); #1;
    check("R10 old base used", entryAddr, 32'hFFFF_F180);
    @(negedge clk);
    takeStrobe = 1'b0; regWrEn = 1'b0;
    mBase = 32'h1234_5000;
    readCheck(1'b0, "R10 write landed");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) writeReg(1'b0, $urandom);
      else if (r == 1) writeReg(1'b1, $urandom);
      else take(($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                6'($urandom), "R8 random");
    end
    readCheck(1'b0, "R2 final base");
    readCheck(1'b1, "R3 final spacing");
    finishRun();
  end

endmodule